// File: doc/BRIEF.md
# Word-Serial Montgomery Multiplier with a Processing-Element Chain

This block computes a Montgomery product Z ≡ X·Y·R⁻¹ (mod M) with R = 2^(W·N). The operands are N words of W bits each. The default is 16 words of 16 bits, a 256-bit product. A chain of N processing elements holds one word position each. In every iteration the element at position j forms its slice of Z + xᵢ·Y + q·M. It keeps the low W bits as a result word and hands its carries to element j+1 one cycle later. The work therefore sweeps down the chain as a single wavefront. The first element's output word is always zero and is dropped, which performs the division by 2^W. The last element also folds the incoming carries into the topmost word.

A controller reads one multiplier word xᵢ per iteration from an external word-addressed store. A one-cycle quotient unit derives q from xᵢ, the lowest words of Y and Z, and the precomputed constant m′ = −M⁻¹ mod 2^W. The multiplicand Y, the modulus M and m′ are presented as stable inputs for the whole operation. When the last wavefront leaves the chain, `done` pulses. The result words can then be read one at a time through a select input. The result is not fully reduced. The input bounds keep it below 2M, so no final subtraction stage exists.

Top module: `mont_sysmul`

## Requirements
- R1: When `done` pulses, the N result words (word 0 least significant) form a value Z with Z·2^(W·N) ≡ X·Y (mod M).
- R2: For odd M with 4M < 2^(W·N) and X, Y < 2M, the result Z is below 2M. No subtraction of M is ever applied.
- R3: The quotient for iteration i is q = (((xᵢ·Y₀ mod 2^W) + Z₀ mod 2^W)·m′) mod 2^W, with `m_prime` supplied as −M⁻¹ mod 2^W. As a result the lowest word of each element-0 sum is zero and is discarded.
- R4: During iteration i, `x_addr` equals i, so the addresses run 0, 1, …, N−1 in ascending order. `x_rdata` must carry the word at `x_addr` in the same cycle.
- R5: `done` is high for exactly one cycle, N·(N+1) rising edges after the edge that accepts `start`. `busy` is high from the accepting edge until `done` rises.
- R6: A `start` pulse while `busy` is high has no effect: the running product, its latency and its result are unchanged.
- R7: `res_word` is combinationally word `res_sel` of Z (word 0 least significant). It keeps its value while the block is idle.
- R8: After reset, `busy` and `done` are low, `x_addr` is 0 and every result word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a product; accepted only while idle |
| y_words | input | W·N | Multiplicand Y, word j at bits [j·W +: W]; held while busy |
| m_words | input | W·N | Odd modulus M, same layout; held while busy |
| m_prime | input | W | −M⁻¹ mod 2^W; held while busy |
| x_rdata | input | W | Multiplier word at `x_addr`, same cycle |
| x_addr | output | log2(N) | Index of the multiplier word needed |
| res_sel | input | log2(N) | Result word select |
| res_word | output | W | Selected result word |
| busy | output | 1 | A product is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The bench targets the corners where carry handling goes wrong. It uses the largest legal modulus with both operands at 2M−1, so every product half and the three-bit sum carry are near their limits. A chain that dropped or misplaced one carry word would produce a value that is not congruent to X·Y·R⁻¹. It also exercises a zero multiplier, unit operands and the smallest odd modulus. A wrong quotient or a misaligned shift would show up there as a non-congruent result. A wrongly bounded result would show up as a value of 2M or more. The bench tracks the address sequence and the exact latency, and it injects a `start` in the middle of a run. A controller that restarted, skipped a word or held the wave one cycle too long would break the address order or the latency count. Result words are read in a scrambled order and then re-read, which exposes a mis-indexed or unstable output multiplexer.

// File: rtl/mont_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the Montgomery multiplier.
// Assumes nothing beyond the parameters of the modules that import it.
package mont_pkg;
    // Width of the per-element sum carry: five W-bit terms plus a 3-bit carry fit in W+3 bits.
    localparam int unsigned CSW = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_QUOT,
        ST_WAVE
    } mm_state_e;
endpackage

// File: rtl/mont_quot.sv
`timescale 1ns/1ps
// Quotient digit unit: q = ((x*y0 mod 2^W) + z0 mod 2^W) * m' mod 2^W.
// Purely combinational; assumes m_prime = -M^-1 mod 2^W so that q*M0 cancels the low word.
module mont_quot #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_word,
    input  logic [W-1:0] y_low,
    input  logic [W-1:0] z_low,
    input  logic [W-1:0] m_prime,
    output logic [W-1:0] q_word
);
    logic [W-1:0] xy_lo;
    logic [W-1:0] part;

    // Three single-precision steps, each truncated to W bits.
    always_comb begin
        xy_lo  = x_word * y_low;
        part   = xy_lo + z_low;
        q_word = part * m_prime;
    end
endmodule

// File: rtl/mont_pe.sv
`timescale 1ns/1ps
// One processing element: forms word j of Z + x*Y + q*M.
// Both products are 2W bits wide. Their low halves are summed with the old Z word and the
// incoming carries (the high product halves of the previous element and its sum carry).
// Outputs the low W bits as a result word and the new carries, all combinational.
// Assumes the caller registers the carries between neighbouring elements.
module mont_pe
    import mont_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   x_word,
    input  logic [W-1:0]   q_word,
    input  logic [W-1:0]   y_word,
    input  logic [W-1:0]   m_word,
    input  logic [W-1:0]   z_word,
    input  logic [W-1:0]   hy_in,
    input  logic [W-1:0]   hm_in,
    input  logic [CSW-1:0] cs_in,
    output logic [W-1:0]   res_word,
    output logic [W-1:0]   hy_out,
    output logic [W-1:0]   hm_out,
    output logic [CSW-1:0] cs_out
);
    logic [2*W-1:0]   prod_y;
    logic [2*W-1:0]   prod_m;
    logic [W+CSW-1:0] acc;

    // Two full products, then one wide accumulation of every W-bit term at this weight.
    always_comb begin
        prod_y = {{W{1'b0}}, x_word} * {{W{1'b0}}, y_word};
        prod_m = {{W{1'b0}}, q_word} * {{W{1'b0}}, m_word};
        acc    = {{CSW{1'b0}}, prod_y[W-1:0]}
               + {{CSW{1'b0}}, prod_m[W-1:0]}
               + {{CSW{1'b0}}, z_word}
               + {{CSW{1'b0}}, hy_in}
               + {{CSW{1'b0}}, hm_in}
               + {{W{1'b0}}, cs_in};
        res_word = acc[W-1:0];
        cs_out   = acc[W+CSW-1:W];
        hy_out   = prod_y[2*W-1:W];
        hm_out   = prod_m[2*W-1:W];
    end
endmodule

// File: rtl/mont_ctrl.sv
`timescale 1ns/1ps
// Sequencer: one quotient cycle then one N-cycle wavefront per iteration, N iterations.
// The multiplier-word address equals the iteration index. start is honoured only when idle.
// Assumes wave_last marks the cycle in which the last element is active.
module mont_ctrl
    import mont_pkg::*;
#(
    parameter int N  = 16,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wave_last,
    output logic [AW-1:0] x_addr,
    output logic          load_q,
    output logic          clr_z,
    output logic          busy,
    output logic          done
);
    mm_state_e     state;
    logic [AW-1:0] iter;

    // State, iteration counter and the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            iter  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_QUOT;
                        iter  <= '0;
                    end
                end
                ST_QUOT: state <= ST_WAVE;
                ST_WAVE: begin
                    if (wave_last) begin
                        if (iter == AW'(N - 1)) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            iter  <= iter + AW'(1);
                            state <= ST_QUOT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decoded strobes for the datapath.
    always_comb begin
        x_addr = iter;
        load_q = (state == ST_QUOT);
        clr_z  = (state == ST_IDLE) && start;
        busy   = (state != ST_IDLE);
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    a_r5_done_after_wave: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(wave_last));
    a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n) (busy && !wave_last) |=> busy);
endmodule

// File: rtl/mont_sysmul.sv
`timescale 1ns/1ps
// Montgomery multiplier, radix 2^W, N words, one processing element per word.
// Each iteration latches x_i and its quotient, then a token walks the element chain.
// Element j reads Z word j and writes the shifted result into Z word j-1; the last element
// also writes words N-1 and the top carry. The carries are registered between elements.
// Assumes Y, M and m_prime are stable while busy and that x_rdata follows x_addr in the same cycle.
module mont_sysmul
    import mont_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 16,
    localparam int AW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W*N-1:0] y_words,
    input  logic [W*N-1:0] m_words,
    input  logic [W-1:0]   m_prime,
    input  logic [W-1:0]   x_rdata,
    output logic [AW-1:0]  x_addr,
    input  logic [AW-1:0]  res_sel,
    output logic [W-1:0]   res_word,
    output logic           busy,
    output logic           done
);
    logic           load_q;
    logic           clr_z;
    logic [N-1:0]   act;
    logic [W-1:0]   x_hold;
    logic [W-1:0]   q_hold;
    logic [W-1:0]   q_now;
    logic [W-1:0]   zw     [N];
    logic [1:0]     z_top;
    logic [W-1:0]   pe_res [N];
    logic [W-1:0]   hy_c   [N];
    logic [W-1:0]   hm_c   [N];
    logic [CSW-1:0] cs_c   [N];
    logic [W-1:0]   hy_r   [N-1];
    logic [W-1:0]   hm_r   [N-1];
    logic [CSW-1:0] cs_r   [N-1];
    logic [W+1:0]   top_sum;

    mont_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wave_last (act[N-1]),
        .x_addr    (x_addr),
        .load_q    (load_q),
        .clr_z     (clr_z),
        .busy      (busy),
        .done      (done)
    );

    mont_quot #(.W(W)) u_quot (
        .x_word  (x_rdata),
        .y_low   (y_words[W-1:0]),
        .z_low   (zw[0]),
        .m_prime (m_prime),
        .q_word  (q_now)
    );

    // Hold the multiplier word and quotient for the whole wavefront.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_hold <= '0;
            q_hold <= '0;
        end else if (load_q) begin
            x_hold <= x_rdata;
            q_hold <= q_now;
        end
    end

    // Activation token: injected after the quotient cycle, moves one element per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) act <= '0;
        else        act <= {act[N-2:0], load_q};
    end

    for (genvar j = 0; j < N; j++) begin : g_pe
        logic [W-1:0]   hy_i;
        logic [W-1:0]   hm_i;
        logic [CSW-1:0] cs_i;
        if (j == 0) begin : g_head
            assign hy_i = '0;
            assign hm_i = '0;
            assign cs_i = '0;
        end else begin : g_body
            assign hy_i = hy_r[j-1];
            assign hm_i = hm_r[j-1];
            assign cs_i = cs_r[j-1];
        end
        mont_pe #(.W(W)) u_pe (
            .x_word   (x_hold),
            .q_word   (q_hold),
            .y_word   (y_words[j*W +: W]),
            .m_word   (m_words[j*W +: W]),
            .z_word   (zw[j]),
            .hy_in    (hy_i),
            .hm_in    (hm_i),
            .cs_in    (cs_i),
            .res_word (pe_res[j]),
            .hy_out   (hy_c[j]),
            .hm_out   (hm_c[j]),
            .cs_out   (cs_c[j])
        );
    end

    // Carry registers between neighbouring elements, loaded when the sender is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N - 1; k++) begin
                hy_r[k] <= '0;
                hm_r[k] <= '0;
                cs_r[k] <= '0;
            end
        end else begin
            for (int k = 0; k < N - 1; k++) begin
                if (act[k]) begin
                    hy_r[k] <= hy_c[k];
                    hm_r[k] <= hm_c[k];
                    cs_r[k] <= cs_c[k];
                end
            end
        end
    end

    // Last element folds its outgoing carries and the old top into the two highest words.
    always_comb begin
        top_sum = {2'b00, hy_c[N-1]}
                + {2'b00, hm_c[N-1]}
                + {{(W+2-CSW){1'b0}}, cs_c[N-1]}
                + {{W{1'b0}}, z_top};
    end

    // Partial result store: cleared on start, shifted down one word as the wave passes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_z) begin
            for (int k = 0; k < N; k++) zw[k] <= '0;
            z_top <= '0;
        end else begin
            for (int k = 0; k < N - 1; k++) begin
                if (act[k+1]) zw[k] <= pe_res[k+1];
            end
            if (act[N-1]) begin
                zw[N-1] <= top_sum[W-1:0];
                z_top   <= top_sum[W+1:W];
            end
        end
    end

    // Output word multiplexer.
    always_comb res_word = zw[res_sel];

    a_r3_low_word_dropped: assert property (@(posedge clk) disable iff (!rst_n) act[0] |-> (pe_res[0] == '0));
    a_r5_one_element_active: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act));
    a_r2_no_top_overflow: assert property (@(posedge clk) disable iff (!rst_n) done |-> (z_top == 2'b00));
endmodule

// File: tb/tb_mont_sysmul.sv
`timescale 1ns/1ps
module tb_mont_sysmul;
    localparam int W  = 16;
    localparam int N  = 16;
    localparam int AW = $clog2(N);
    localparam int NW = W * N;
    localparam int LAT = N * (N + 1);

    typedef struct {
        logic [NW-1:0] m;
        logic [NW-1:0] want;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] y_words = '0;
    logic [NW-1:0] m_words = '0;
    logic [W-1:0]  m_prime = '0;
    logic [W-1:0]  x_rdata;
    logic [AW-1:0] x_addr;
    logic [AW-1:0] res_sel = '0;
    logic [W-1:0]  res_word;
    logic          busy;
    logic          done;
    logic [W-1:0]  xmem [N];

    int   total = 0;
    int   bad = 0;
    int   seen = 0;
    int   ncase = 0;
    exp_t sbq[$];

    always #10 clk = ~clk;

    always_comb x_rdata = xmem[x_addr];

    mont_sysmul #(.W(W), .N(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .y_words(y_words), .m_words(m_words),
        .m_prime(m_prime), .x_rdata(x_rdata), .x_addr(x_addr), .res_sel(res_sel),
        .res_word(res_word), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [NW-1:0] got, input logic [NW-1:0] want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h want=%h", req, got, want);
        end
    endtask

    function automatic logic [W-1:0] calc_mprime(input logic [W-1:0] m0);
        logic [W-1:0] inv;
        inv = 1;
        repeat (5) inv = inv * (W'(2) - m0 * inv);
        return W'(0) - inv;
    endfunction

    function automatic logic [NW-1:0] rnd_wide();
        logic [NW-1:0] r;
        for (int k = 0; k < NW / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [NW-1:0] rnd_below(input logic [NW:0] lim);
        logic [NW:0] t;
        t = {1'b0, rnd_wide()} % lim;
        return t[NW-1:0];
    endfunction

    // Monitor: on done, pop the expected item, read all words in a scrambled order, compare.
    initial begin
        exp_t          e;
        logic [NW-1:0] z;
        logic [2*NW-1:0] lhs;
        int            s;
        forever begin
            @(negedge clk);
            if (done) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R5 unexpected done", '0, '0);
                end else begin
                    e = sbq.pop_front();
                    for (int k = 0; k < N; k++) begin
                        s = (k * 5) % N;
                        res_sel = AW'(s);
                        @(negedge clk);
                        z[s*W +: W] = res_word;
                    end
                    lhs = {z, {NW{1'b0}}} % {{NW{1'b0}}, e.m};
                    chk(lhs[NW-1:0] == e.want && lhs[2*NW-1:NW] == '0, "R1/R3 congruence", lhs[NW-1:0], e.want);
                    chk({1'b0, z} < {e.m, 1'b0}, "R2 below 2M", z, e.m);
                    res_sel = '0;
                    repeat (3) @(negedge clk);
                    chk(res_word == z[W-1:0], "R7 word held", NW'(res_word), NW'(z[W-1:0]));
                end
                seen++;
            end
        end
    end

    // Driver: push the expectation, start, track addresses and latency, optionally poke start.
    task automatic run_case(input logic [NW-1:0] xv, input logic [NW-1:0] yv, input logic [NW-1:0] mv, input int poke_at);
        logic [2*NW-1:0] prod;
        exp_t e;
        int   lat;
        int   last;
        for (int k = 0; k < N; k++) xmem[k] = xv[k*W +: W];
        y_words = yv;
        m_words = mv;
        m_prime = calc_mprime(mv[W-1:0]);
        prod = ({{NW{1'b0}}, xv} * {{NW{1'b0}}, yv}) % {{NW{1'b0}}, mv};
        e.m = mv;
        e.want = prod[NW-1:0];
        sbq.push_back(e);
        ncase++;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R5 busy after start", NW'(busy), NW'(1));
        lat = 0;
        last = -1;
        while (!done && lat < 2000) begin
            if (int'(x_addr) != last) begin
                chk(int'(x_addr) == last + 1, "R4 address order", NW'(x_addr), NW'(last + 1));
                last = int'(x_addr);
            end
            @(negedge clk);
            lat++;
            start = (poke_at > 0 && lat == poke_at);
            if (poke_at > 0 && lat == poke_at + 1)
                chk(busy == 1'b1, "R6 still busy", NW'(busy), NW'(1));
        end
        start = 1'b0;
        chk(last == N - 1, "R4 last address", NW'(last), NW'(N - 1));
        chk(lat == LAT, poke_at > 0 ? "R6 latency with stray start" : "R5 latency", NW'(lat), NW'(LAT));
        @(negedge clk);
        chk(done == 1'b0, "R5 single-cycle done", NW'(done), NW'(0));
        while (seen < ncase) @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        repeat (148000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NW-1:0] mv;
        logic [NW-1:0] big;
        for (int k = 0; k < N; k++) xmem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy", NW'(busy), NW'(0));
        chk(done == 1'b0, "R8 done", NW'(done), NW'(0));
        chk(x_addr == '0, "R8 address", NW'(x_addr), NW'(0));
        res_sel = AW'(N - 1);
        @(negedge clk);
        chk(res_word == '0, "R8 result word", NW'(res_word), NW'(0));
        res_sel = '0;

        // Largest legal modulus, operands at 2M-1: carries at their extremes.
        big = {2'b00, {(NW-2){1'b1}}};
        run_case({big[NW-2:0], 1'b0} - NW'(1), {big[NW-2:0], 1'b0} - NW'(1), big, 0);
        // Zero multiplier.
        mv = rnd_wide(); mv[NW-1:NW-2] = 2'b00; mv[0] = 1'b1;
        run_case('0, rnd_below({mv, 1'b0}), mv, 0);
        // Unit operands.
        run_case(NW'(1), NW'(1), mv, 0);
        // Smallest odd modulus.
        run_case(NW'(5), NW'(4), NW'(3), 0);
        // Random moduli and operands; one run gets a stray start mid-flight.
        for (int c = 0; c < 6; c++) begin
            mv = rnd_wide(); mv[NW-1:NW-2] = 2'b00; mv[0] = 1'b1; mv[NW-3] = 1'b1;
            run_case(rnd_below({mv, 1'b0}), rnd_below({mv, 1'b0}), mv, (c == 2) ? 50 : 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule